// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block is the sending side of an asynchronous serial port paced by a 16x bit-rate enable. A host pushes bytes through a valid/ready write port into a 16-deep buffer. A frame sequencer takes the oldest byte and puts it on the line as one frame, in this order: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and a high stop period of 1, 1.5 or 2 bit times. A break request holds the line low for as long as it is asserted.

The write port follows valid/ready rules. A byte transfers only on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the buffer holds 16 bytes, so an offered byte waits or is lost and never overwrites stored data. `wr_ready` depends only on the buffer fill, never on `wr_valid`. Frame settings are captured when a frame starts, so a change to them applies to the next frame. Three plain status outputs report the buffer and the line: buffer empty, all sent, and a DMA pacing request.

Top module: `serial_tx_engine`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `txd` is high. Reset also sets `wr_ready`, `fifo_empty`, `tx_empty` and `dma_ready` to 1.
- R2: `cfg_len` sets the number of data bits: code 0 sends 5, code 1 sends 6, code 2 sends 7 and code 3 sends 8. The bits go out with bit 0 first. Unused upper bits of the byte are not sent.
- R3: When `cfg_par_en` is 1, a parity bit follows the data bits. With `cfg_par_odd`=0 the parity bit makes the count of ones over the data bits and the parity bit even. With `cfg_par_odd`=1 it makes that count odd. When `cfg_par_en` is 0, no parity bit is sent.
- R4: `cfg_stop` sets the length of the high stop period: code 0 lasts 16 ticks, code 1 lasts 24 ticks, and codes 2 and 3 last 32 ticks.
- R5: The start, data and parity bits each last exactly 16 cycles in which `tick16` is high. The start bit is low. The frame begins on the clock edge after a byte is available while the line is idle. `cfg_*` is sampled at that edge.
- R6: While `brk` is high, `txd` is low in the same cycle. Frame timing continues underneath, so the line shows the frame's current bit again when `brk` falls.
- R7: The buffer holds 16 bytes and sends them in the order they were written. `wr_ready` is 0 exactly when 16 bytes are stored, and a byte offered then is not stored.
- R8: `fifo_empty` is 1 exactly when the buffer holds no byte.
- R9: `tx_empty` is 1 only when the buffer is empty and no frame is in progress. It rises on the clock edge after the last stop tick.
- R10: `dma_ready` is set on the edge after a cycle in which the buffer is empty. It is cleared on the edge after a cycle in which the buffer is full. Otherwise it holds its value.
- R11: If a byte is waiting when the last stop tick occurs, the next start bit begins on the next edge, with no idle time between the frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | 16x bit-rate enable, one clock wide |
| wr_valid | input | 1 | Host offers a byte |
| wr_data | input | 8 | Offered byte |
| wr_ready | output | 1 | Buffer can accept a byte |
| cfg_len | input | 2 | Data length code (5 + code bits) |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_stop | input | 2 | Stop period code |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial line |
| fifo_empty | output | 1 | Buffer holds no byte |
| tx_empty | output | 1 | Buffer empty and line idle |
| dma_ready | output | 1 | DMA pacing request with hysteresis |

## Verification
Two events can fall in the same cycle: a host write accepted on the same edge at which the sequencer pops the buffer for a new frame, and a break assertion on the same edge as a bit boundary or a frame hand-over. The bench provokes the first by writing continuously, including with `tick16` high on every cycle, so that pushes land on the stop-end edge, on the idle-start edge and on a full buffer. It provokes the second by pulsing `brk` across bit boundaries. A queue-based model advanced on every edge judges the result: stored order, buffer occupancy, flag timing and the line level are compared in every cycle.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int BIT_TICKS = 16;
  localparam int TCW       = $clog2(2 * BIT_TICKS);

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } phase_t;

  // last tick index of the stop period: 1, 1.5 or 2 bit times
  function automatic logic [TCW-1:0] stop_last(input logic [1:0] code);
    case (code)
      2'd0:    stop_last = TCW'(BIT_TICKS - 1);
      2'd1:    stop_last = TCW'(BIT_TICKS + BIT_TICKS / 2 - 1);
      default: stop_last = TCW'(2 * BIT_TICKS - 1);
    endcase
  endfunction
endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    bump = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign dout  = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/stx_framer.sv
module stx_framer
  import stx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       avail,
  input  logic [7:0] data,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_stop,
  input  logic       brk,
  output logic       take,
  output logic       busy,
  output logic       txd
);
  localparam logic [TCW-1:0] BIT_LAST = TCW'(BIT_TICKS - 1);

  phase_t         ph;
  logic [TCW-1:0] tcnt;
  logic [2:0]     bidx;
  logic [7:0]     sh;
  logic           par_bit;
  logic [1:0]     l_len;
  logic [1:0]     l_stop;
  logic           l_par_en;

  logic       bit_end, stop_done, line_bit, new_par;
  logic [7:0] mask;

  assign bit_end   = tick && (tcnt == BIT_LAST);
  assign stop_done = (ph == PH_STOP) && tick && (tcnt == stop_last(l_stop));
  assign take      = avail && ((ph == PH_IDLE) || stop_done);
  assign mask      = 8'hFF >> (2'd3 - cfg_len);
  assign new_par   = (^(data & mask)) ^ cfg_par_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      tcnt     <= '0;
      bidx     <= '0;
      sh       <= '0;
      par_bit  <= 1'b0;
      l_len    <= '0;
      l_stop   <= '0;
      l_par_en <= 1'b0;
    end else if (take) begin
      ph       <= PH_START;
      tcnt     <= '0;
      bidx     <= '0;
      sh       <= data;
      par_bit  <= new_par;
      l_len    <= cfg_len;
      l_stop   <= cfg_stop;
      l_par_en <= cfg_par_en;
    end else if (tick) begin
      case (ph)
        PH_START: begin
          tcnt <= bit_end ? '0 : tcnt + TCW'(1);
          if (bit_end) ph <= PH_DATA;
        end
        PH_DATA: begin
          if (bit_end) begin
            tcnt <= '0;
            sh   <= sh >> 1;
            if (bidx == 3'd4 + {1'b0, l_len}) ph <= l_par_en ? PH_PAR : PH_STOP;
            else bidx <= bidx + 3'd1;
          end else begin
            tcnt <= tcnt + TCW'(1);
          end
        end
        PH_PAR: begin
          tcnt <= bit_end ? '0 : tcnt + TCW'(1);
          if (bit_end) ph <= PH_STOP;
        end
        PH_STOP: begin
          if (stop_done) begin
            tcnt <= '0;
            ph   <= PH_IDLE;
          end else begin
            tcnt <= tcnt + TCW'(1);
          end
        end
        default: tcnt <= '0;
      endcase
    end
  end

  always_comb begin
    case (ph)
      PH_START: line_bit = 1'b0;
      PH_DATA:  line_bit = sh[0];
      PH_PAR:   line_bit = par_bit;
      default:  line_bit = 1'b1;
    endcase
  end

  assign busy = (ph != PH_IDLE);
  assign txd  = line_bit & ~brk;
endmodule

// File: rtl/stx_dma_pace.sv
module stx_dma_pace (
  input  logic clk,
  input  logic rst_n,
  input  logic buf_empty,
  input  logic buf_full,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req <= 1'b1;
    else if (buf_empty) req <= 1'b1;
    else if (buf_full)  req <= 1'b0;
  end
endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_stop,
  input  logic       brk,
  output logic       txd,
  output logic       fifo_empty,
  output logic       tx_empty,
  output logic       dma_ready
);
  logic       buf_full, buf_empty, push, take, ser_busy;
  logic [7:0] head;

  assign push = wr_valid && !buf_full;

  stx_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(wr_data), .pop(take),
    .dout(head), .full(buf_full), .empty(buf_empty)
  );

  stx_framer u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .avail(!buf_empty), .data(head),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop(cfg_stop), .brk(brk), .take(take), .busy(ser_busy), .txd(txd)
  );

  stx_dma_pace u_pace (
    .clk(clk), .rst_n(rst_n), .buf_empty(buf_empty), .buf_full(buf_full),
    .req(dma_ready)
  );

  assign wr_ready   = !buf_full;
  assign fifo_empty = buf_empty;
  assign tx_empty   = buf_empty && !ser_busy;
endmodule

// File: rtl/serial_tx_checker.sv
module serial_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic brk,
  input logic wr_ready,
  input logic txd,
  input logic fifo_empty,
  input logic tx_empty,
  input logic dma_ready,
  input logic ser_busy
);
  a_r6_break_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk) |-> txd);

  a_r9_done_needs_empty_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> fifo_empty);

  a_r7_full_is_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !fifo_empty);

  a_r10_empty_arms_dma: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |=> dma_ready);

  a_r10_full_drops_dma: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> !dma_ready);

  a_r5_line_holds_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_busy && !tick16 && !brk) ##1 !brk |-> $stable(txd));
endmodule

bind serial_tx_engine serial_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .brk(brk), .wr_ready(wr_ready),
  .txd(txd), .fifo_empty(fifo_empty), .tx_empty(tx_empty),
  .dma_ready(dma_ready), .ser_busy(ser_busy)
);

// File: tb/serial_tx_engine_tb.sv
`timescale 1ns/1ps
module serial_tx_engine_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = 2'd0;
  logic       brk = 1'b0;
  logic       wr_ready, txd, fifo_empty, tx_empty, dma_ready;

  int n_cmp = 0;
  int n_bad = 0;
  int tick_div = 2;
  int tick_cnt = 0;
  bit started = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_tx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
    .brk(brk), .txd(txd), .fifo_empty(fifo_empty), .tx_empty(tx_empty),
    .dma_ready(dma_ready)
  );

  // tick generator, driven away from the active edge
  always @(negedge clk) begin
    tick16 <= (tick_cnt == tick_div - 1);
    tick_cnt <= (tick_cnt >= tick_div - 1) ? 0 : tick_cnt + 1;
  end

  // ---------------- reference model ----------------
  logic [7:0] q[$];
  int   m_ph = 0;           // 0 idle, 1 start, 2 data, 3 parity, 4 stop
  int   m_cnt = 0, m_idx = 0, m_bits = 8, m_stop_ticks = 16;
  logic [7:0] m_sh = 8'h00;
  bit   m_par = 0, m_par_en = 0, m_dma = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_ph = 0; m_cnt = 0; m_idx = 0; m_dma = 1;
    end else begin
      automatic int  sz = q.size();
      automatic bit  push = wr_valid && (sz < 16);
      automatic bit  stop_end = (m_ph == 4) && tick16 && (m_cnt == m_stop_ticks - 1);
      automatic bit  take = (sz > 0) && ((m_ph == 0) || stop_end);
      started = 1;
      if (sz == 0) m_dma = 1;
      else if (sz == 16) m_dma = 0;
      if (take) begin
        automatic int ones = 0;
        m_sh = q.pop_front();
        m_bits = 5 + cfg_len;
        for (int i = 0; i < m_bits; i++) ones += m_sh[i];
        m_par = cfg_par_odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
        m_par_en = cfg_par_en;
        m_stop_ticks = (cfg_stop == 0) ? 16 : (cfg_stop == 1) ? 24 : 32;
        m_ph = 1; m_cnt = 0; m_idx = 0;
      end else if (tick16 && m_ph != 0) begin
        automatic int limit = (m_ph == 4) ? m_stop_ticks : 16;
        if (m_cnt + 1 < limit) m_cnt++;
        else begin
          m_cnt = 0;
          case (m_ph)
            1: m_ph = 2;
            2: begin
                 m_sh = m_sh >> 1;
                 if (m_idx == m_bits - 1) m_ph = m_par_en ? 3 : 4;
                 else m_idx++;
               end
            3: m_ph = 4;
            default: m_ph = 0;
          endcase
        end
      end
      if (push) q.push_back(wr_data);
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // compare on every cycle, after the falling edge
  always @(negedge clk) begin
    #1;
    if (started && !done) begin
      automatic logic  e_txd;
      automatic string tag;
      case (m_ph)
        1: begin e_txd = 1'b0;     tag = "R5 start bit"; end       // also R11 hand-over
        2: begin e_txd = m_sh[0];  tag = "R2 data bit"; end
        3: begin e_txd = m_par;    tag = "R3 parity bit"; end
        4: begin e_txd = 1'b1;     tag = "R4 stop period"; end
        default: begin e_txd = 1'b1; tag = "R1 idle line"; end
      endcase
      if (brk) begin e_txd = 1'b0; tag = "R6 break"; end
      check(tag, txd, e_txd);
      check("R7 wr_ready", wr_ready, q.size() < 16);
      check("R8 fifo_empty", fifo_empty, q.size() == 0);
      check("R9 tx_empty", tx_empty, (q.size() == 0) && (m_ph == 0));
      check("R10 dma_ready", dma_ready, m_dma);
    end
  end

  task automatic put(input logic [7:0] b);
    wr_valid = 1'b1; wr_data = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40000; i++) begin
      if (tx_empty) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset txd", txd, 1'b1);
    check("R1 reset wr_ready", wr_ready, 1'b1);
    check("R1 reset fifo_empty", fifo_empty, 1'b1);
    check("R1 reset tx_empty", tx_empty, 1'b1);
    check("R1 reset dma_ready", dma_ready, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 8 bits, no parity, one stop
    put(8'hA5); drain();
    // R3 even parity, 5 bits, R4 1.5 stop
    cfg_len = 2'd0; cfg_par_en = 1; cfg_par_odd = 0; cfg_stop = 2'd1;
    put(8'hF3); put(8'h16); drain();
    // R3 odd parity, 6 bits, two stops; R11 back-to-back
    cfg_len = 2'd1; cfg_par_odd = 1; cfg_stop = 2'd2;
    put(8'h3C); put(8'hC1); put(8'h00); drain();
    // 7 bits, stop code 3
    cfg_len = 2'd2; cfg_par_en = 0; cfg_stop = 2'd3;
    put(8'h7F); drain();

    // R7 overfill: held valid for 22 cycles, R10 hysteresis
    cfg_len = 2'd3; cfg_stop = 2'd0;
    for (int i = 0; i < 22; i++) put(8'(8'h40 + i));
    // R5 settings changed mid-frame apply to the next frame only
    cfg_par_en = 1; cfg_len = 2'd1;
    // R6 break pulses across bit boundaries
    repeat (37) @(negedge clk);
    brk = 1; repeat (45) @(negedge clk); brk = 0;
    repeat (20) @(negedge clk);
    brk = 1; @(negedge clk); brk = 0;
    drain();

    // tick on every cycle: pushes collide with stop-end pops
    tick_div = 1;
    cfg_par_en = 0; cfg_len = 2'd3; cfg_stop = 2'd0;
    for (int i = 0; i < 40; i++) begin
      put(8'(8'h91 * i + 3));
      repeat (i % 23) @(negedge clk);
    end
    drain();
    for (int i = 0; i < 20; i++) put(8'(i * 7));
    drain();

    finish_run();
  end
endmodule